// File: doc/BRIEF.md
# Peripheral Request Router with Grouped Priority Arbiter

This block sits between a set of numbered peripheral DMA request lines and a bank of DMA channels. Software programs one mapping register per peripheral request; each mapping carries a valid flag and a target channel number. Every clock, each valid mapping steers its peripheral request onto the selected channel's request output. Several peripherals may share one channel, and their requests are then combined.

A second function picks which busy channel owns the shared bus in the next cycle. Channels fall into four priority levels taken from bits 3:2 of their index, so the level pattern repeats every sixteen channels. Among channels on the same level, the lowest index wins. A third function reduces each channel's interrupt status flags into one summary bit per channel. The summary word is readable through the register port and is also driven straight out.

The register port is a plain single-cycle write strobe with a combinational read. The channel data engines, which consume the routed requests and the grant, are outside this block.

Top module: `periph_req_router`

## Requirements
- R1: A synchronous active-low reset clears every mapping to invalid, and `chan_req` and `grant` read zero in the cycle after reset is applied.
- R2: A mapping register stores bit 7 of the written word as the valid flag and bits 4:0 as the target channel. Reading it returns those bits in the same positions, with every other bit zero.
- R3: The mapping for request n < 64 is at byte address 0x100 + 4n. The mapping for request n >= 64 is at 0x1100 + 4(n - 64). Writes to unaligned addresses, or to addresses whose request number is not implemented, change nothing, and reading such addresses returns zero.
- R4: When a valid mapping sends request n to channel c, `chan_req[c]` equals `periph_req[n]` delayed by one clock.
- R5: A mapping with the valid bit clear routes its request to no channel. Writing zero to a mapping removes a route that was in place.
- R6: When two or more valid mappings target the same channel, that channel's request is the OR of their requests.
- R7: `grant` is registered from `ch_busy` one clock earlier. It is one-hot when any channel was busy and all zero otherwise, and the granted channel was busy.
- R8: The priority level of channel i is bits 3:2 of i, with 0 the most urgent. The grant never goes to a channel when a busy channel of a more urgent level exists.
- R9: Among busy channels of the most urgent busy level, the grant goes to the lowest index.
- R10: `irq_summary[c]` is the OR of channel c's `IRQ_W` status flags. It follows the flags combinationally, so it sets and clears in the same cycle as they do. The summary word is read at address 0x080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | NUM_REQ | Raw peripheral request lines, one per request number |
| ch_busy | input | NUM_CH | Channel wants the shared bus |
| ch_irq_status | input | NUM_CH*IRQ_W | Interrupt status flags; channel c owns bits c*IRQ_W +: IRQ_W |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address for both write and read |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Combinational read data for `reg_addr` |
| chan_req | output | NUM_CH | Routed request per channel, registered |
| grant | output | NUM_CH | One-hot bus grant, registered |
| irq_summary | output | NUM_CH | Per-channel interrupt summary |

## Verification
The bound checker watches the arbiter on every cycle. It checks that the grant is at most one-hot and that it follows the previous cycle's busy set. It also checks that no more urgent level and no lower index at the winning level was passed over. On top of that, it checks that the outputs go quiet after reset and that routed requests never appear without some peripheral request behind them. The address decode itself can only be shown by the bench's scenarios: the two mapping banks, ignored unaligned and out-of-range writes, field readback, the steering of a specific request to a specific channel, OR-merging and route removal. The same holds for the same-cycle behaviour of the interrupt summary.

// File: rtl/prr_pkg.sv
// Shared constants, the mapping entry type and the priority-level helper for
// the peripheral request router. Assumes at most 128 request lines and at most
// 32 channels, so a 5-bit channel field and a 7-bit request index suffice.
package prr_pkg;

    localparam int MAP_VALID_BIT  = 7;
    localparam int MAP_CH_W       = 5;
    localparam int REQ_IDX_W      = 7;
    localparam int BANK_ENTRIES   = 64;
    localparam int BANK_BYTES     = BANK_ENTRIES * 4;
    localparam int LO_BANK_BASE   = 'h0100;
    localparam int HI_BANK_BASE   = 'h1100;
    localparam int SUMMARY_ADDR   = 'h0080;
    localparam int NUM_LEVELS     = 4;

    typedef struct packed {
        logic                valid;
        logic [MAP_CH_W-1:0] chan;
    } map_entry_t;

    // Priority level of a channel: bits 3:2 of its index, 0 most urgent.
    function automatic logic [1:0] prio_level(input int idx);
        return 2'((idx >> 2) & 3);
    endfunction

endpackage

// File: rtl/prr_map_bank.sv
// Mapping register bank: one entry per peripheral request, split across a low
// and a high address window. Decodes the byte address, applies writes and
// offers the addressed entry for readback. Assumes ADDR_W >= 13 so that both
// windows are reachable, and NUM_REQ <= 128.
module prr_map_bank
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 72,
    parameter int ADDR_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output map_entry_t        map_q [NUM_REQ],
    output logic              rd_hit,
    output map_entry_t        rd_entry
);

    logic [ADDR_W-1:0]    off_lo;
    logic [ADDR_W-1:0]    off_hi;
    logic                 in_lo;
    logic                 in_hi;
    logic                 aligned;
    logic [REQ_IDX_W-1:0] dec_idx;
    logic                 dec_hit;
    map_entry_t           wr_entry;
    logic                 unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[31:MAP_VALID_BIT+1],
                              wr_data[MAP_VALID_BIT-1:MAP_CH_W]};

    // Decode the byte address into a request index and a hit flag.
    always_comb begin
        off_lo  = addr - ADDR_W'(LO_BANK_BASE);
        off_hi  = addr - ADDR_W'(HI_BANK_BASE);
        in_lo   = off_lo < ADDR_W'(BANK_BYTES);
        in_hi   = off_hi < ADDR_W'(BANK_BYTES);
        aligned = (addr[1:0] == 2'b00);
        if (in_hi) begin
            dec_idx = {1'b1, off_hi[7:2]};
        end else begin
            dec_idx = {1'b0, off_lo[7:2]};
        end
        dec_hit = (in_lo || in_hi) && aligned && (32'(dec_idx) < NUM_REQ);
    end

    // Pick the stored fields out of the write word.
    always_comb begin
        wr_entry.valid = wr_data[MAP_VALID_BIT];
        wr_entry.chan  = wr_data[MAP_CH_W-1:0];
    end

    // Hold the mapping entries; one decoded entry is updated per write.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NUM_REQ; p++) begin
            if (!rst_n) begin
                map_q[p] <= '0;
            end else if (wr_en && dec_hit && (dec_idx == REQ_IDX_W'(p))) begin
                map_q[p] <= wr_entry;
            end
        end
    end

    // Select the addressed entry for readback.
    always_comb begin
        rd_entry = '0;
        for (int p = 0; p < NUM_REQ; p++) begin
            if (dec_idx == REQ_IDX_W'(p)) begin
                rd_entry = map_q[p];
            end
        end
        if (!dec_hit) begin
            rd_entry = '0;
        end
        rd_hit = dec_hit;
    end

endmodule

// File: rtl/prr_crossbar.sv
// Request crossbar: for every channel, ORs together the peripheral requests
// whose valid mapping names that channel, and registers the result. Assumes
// a mapping whose channel number is at or above NUM_CH routes nowhere.
module prr_crossbar
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 72,
    parameter int NUM_CH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  map_entry_t        map_q [NUM_REQ],
    input  logic [NUM_REQ-1:0] periph_req,
    output logic [NUM_CH-1:0] chan_req
);

    logic [NUM_CH-1:0] route_d;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        logic hit;

        // Gather every valid mapping that names this channel.
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < NUM_REQ; p++) begin
                if (map_q[p].valid && (map_q[p].chan == MAP_CH_W'(c)) && periph_req[p]) begin
                    hit = 1'b1;
                end
            end
        end

        assign route_d[c] = hit;
    end

    // Register the routed requests toward the channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_req <= '0;
        end else begin
            chan_req <= route_d;
        end
    end

endmodule

// File: rtl/prr_arbiter.sv
// Grouped fixed-priority arbiter: the level of a channel is bits 3:2 of its
// index, with level 0 most urgent. The lowest index wins within a level. The
// grant is registered and is one-hot or zero.
module prr_arbiter
    import prr_pkg::*;
#(
    parameter int NUM_CH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] busy,
    output logic [NUM_CH-1:0] grant
);

    logic [NUM_CH-1:0] win_d;
    logic [NUM_LEVELS-1:0] level_any;

    // Flag which priority levels have at least one busy channel.
    always_comb begin
        level_any = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (busy[i]) begin
                level_any[prio_level(i)] = 1'b1;
            end
        end
    end

    // Scan the most urgent busy level for its lowest busy index.
    always_comb begin
        logic done;
        logic [1:0] top_lvl;
        top_lvl = 2'd0;
        done    = 1'b0;
        for (int l = 0; l < NUM_LEVELS; l++) begin
            if (!done && level_any[l]) begin
                top_lvl = 2'(l);
                done    = 1'b1;
            end
        end
        win_d = '0;
        done  = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!done && busy[i] && (prio_level(i) == top_lvl)) begin
                win_d[i] = 1'b1;
                done     = 1'b1;
            end
        end
    end

    // Register the grant for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant <= '0;
        end else begin
            grant <= win_d;
        end
    end

endmodule

// File: rtl/prr_irq_gather.sv
// Interrupt summary: one bit per channel, set while any of that channel's
// status flags is set. Purely combinational, so it tracks the flags in the
// same cycle.
module prr_irq_gather #(
    parameter int NUM_CH = 32,
    parameter int IRQ_W  = 4
) (
    input  logic [NUM_CH*IRQ_W-1:0] status,
    output logic [NUM_CH-1:0]       summary
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sum
        // Reduce this channel's flags to one bit.
        assign summary[c] = |status[c*IRQ_W +: IRQ_W];
    end

endmodule

// File: rtl/periph_req_router.sv
// Top of the peripheral request router. Ties the mapping bank, the request
// crossbar, the grouped priority arbiter and the interrupt summary together,
// and muxes register readback. Assumes NUM_CH <= 32 and NUM_REQ <= 128.
module periph_req_router
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 72,
    parameter int NUM_CH  = 32,
    parameter int IRQ_W   = 4,
    parameter int ADDR_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_REQ-1:0]      periph_req,
    input  logic [NUM_CH-1:0]       ch_busy,
    input  logic [NUM_CH*IRQ_W-1:0] ch_irq_status,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wr_data,
    output logic [31:0]             reg_rd_data,
    output logic [NUM_CH-1:0]       chan_req,
    output logic [NUM_CH-1:0]       grant,
    output logic [NUM_CH-1:0]       irq_summary
);

    localparam int GAP_W = MAP_VALID_BIT - MAP_CH_W;

    map_entry_t map_q [NUM_REQ];
    logic       rd_hit;
    map_entry_t rd_entry;

    prr_map_bank #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wr_data  (reg_wr_data),
        .map_q    (map_q),
        .rd_hit   (rd_hit),
        .rd_entry (rd_entry)
    );

    prr_crossbar #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_xbar (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_q      (map_q),
        .periph_req (periph_req),
        .chan_req   (chan_req)
    );

    prr_arbiter #(.NUM_CH(NUM_CH)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (ch_busy),
        .grant (grant)
    );

    prr_irq_gather #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W)) u_irq (
        .status  (ch_irq_status),
        .summary (irq_summary)
    );

    // Return the summary word, a mapping entry, or zero.
    always_comb begin
        if (reg_addr == ADDR_W'(SUMMARY_ADDR)) begin
            reg_rd_data = 32'(irq_summary);
        end else if (rd_hit) begin
            reg_rd_data = 32'({rd_entry.valid, {GAP_W{1'b0}}, rd_entry.chan});
        end else begin
            reg_rd_data = '0;
        end
    end

endmodule

// File: rtl/periph_req_router_chk.sv
// Checker for the peripheral request router, attached by bind. It keeps its
// own copy of last cycle's busy set and judges the registered grant against
// it. Assumes the default-sized channel count (the grant check loops are
// NUM_CH squared).
module periph_req_router_chk
    import prr_pkg::*;
#(
    parameter int NUM_REQ = 72,
    parameter int NUM_CH  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_REQ-1:0] periph_req,
    input logic [NUM_CH-1:0]  ch_busy,
    input logic [NUM_CH-1:0]  chan_req,
    input logic [NUM_CH-1:0]  grant
);

    logic [NUM_CH-1:0] busy_d;
    logic              level_bad;
    logic              tie_bad;

    // Remember the busy set the grant was computed from.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_d <= '0;
        end else begin
            busy_d <= ch_busy;
        end
    end

    // Look for a busy channel that should have beaten the granted one.
    always_comb begin
        level_bad = 1'b0;
        tie_bad   = 1'b0;
        for (int g = 0; g < NUM_CH; g++) begin
            for (int j = 0; j < NUM_CH; j++) begin
                if (grant[g] && busy_d[j]) begin
                    if (prio_level(j) < prio_level(g)) begin
                        level_bad = 1'b1;
                    end
                    if ((prio_level(j) == prio_level(g)) && (j < g)) begin
                        tie_bad = 1'b1;
                    end
                end
            end
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (grant == '0 && chan_req == '0)); // R1
    AST_NO_SOURCE_NO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n) (periph_req == '0) |=> (chan_req == '0)); // R4
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant)); // R7
    AST_GRANT_WAS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (grant & ~busy_d) == '0); // R7
    AST_BUSY_GETS_GRANT: assert property (@(posedge clk) disable iff (!rst_n) (busy_d != '0) |-> ($countones(grant) == 1)); // R7
    AST_LEVEL_ORDER: assert property (@(posedge clk) disable iff (!rst_n) !level_bad); // R8
    AST_LOW_INDEX_TIE: assert property (@(posedge clk) disable iff (!rst_n) !tie_bad); // R9

endmodule

bind periph_req_router periph_req_router_chk #(
    .NUM_REQ (NUM_REQ),
    .NUM_CH  (NUM_CH)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .ch_busy    (ch_busy),
    .chan_req   (chan_req),
    .grant      (grant)
);

// File: tb/tb_periph_req_router.sv
// Bench for the peripheral request router: an arbiter vector table walked by
// one loop, then directed register, routing and summary tests.
module tb_periph_req_router;

    localparam int NUM_REQ = 72;
    localparam int NUM_CH  = 32;
    localparam int IRQ_W   = 4;
    localparam int ADDR_W  = 16;
    localparam int N_VEC   = 10;

    // {busy set, expected grant one cycle later}
    localparam logic [63:0] ARB_VEC [N_VEC] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0001},
        {32'h8000_0000, 32'h8000_0000},
        {32'h0001_0010, 32'h0001_0000},
        {32'hF000_0F00, 32'h0000_0100},
        {32'h0008_0008, 32'h0000_0008},
        {32'h1000_1000, 32'h0000_1000},
        {32'h0020_8000, 32'h0020_0000},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'h0010_00F0, 32'h0000_0010}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NUM_REQ-1:0]      periph_req = '0;
    logic [NUM_CH-1:0]       ch_busy = '0;
    logic [NUM_CH*IRQ_W-1:0] ch_irq_status = '0;
    logic                    reg_wr_en = 1'b0;
    logic [ADDR_W-1:0]       reg_addr = '0;
    logic [31:0]             reg_wr_data = '0;
    logic [31:0]             reg_rd_data;
    logic [NUM_CH-1:0]       chan_req;
    logic [NUM_CH-1:0]       grant;
    logic [NUM_CH-1:0]       irq_summary;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    periph_req_router #(
        .NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH), .IRQ_W(IRQ_W), .ADDR_W(ADDR_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ch_busy(ch_busy),
        .ch_irq_status(ch_irq_status), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data), .chan_req(chan_req),
        .grant(grant), .irq_summary(irq_summary)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_addr    = a;
        reg_wr_data = d;
        reg_wr_en   = 1'b1;
        tick();
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic route(input int n, input logic [31:0] exp, input string req);
        periph_req    = '0;
        periph_req[n] = 1'b1;
        tick();
        chk(req, 32'(chan_req), exp);
        periph_req = '0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        @(negedge clk);
        periph_req = '1;
        ch_busy    = '1;
        repeat (3) tick();
        // R1: reset state
        chk("R1 chan_req after reset", 32'(chan_req), 32'h0);
        chk("R1 grant after reset", 32'(grant), 32'h0);
        rst_n = 1'b1;
        periph_req = '0;
        ch_busy    = '0;
        tick();
        rd(16'h0100, v);
        chk("R1 mapping 0 cleared", v, 32'h0);

        // R7 R8 R9: arbiter vector table
        for (int i = 0; i < N_VEC; i++) begin
            ch_busy = ARB_VEC[i][63:32];
            tick();
            chk($sformatf("R7/R8/R9 grant vec %0d", i), 32'(grant), ARB_VEC[i][31:0]);
        end
        ch_busy = '0;
        tick();
        chk("R7 idle gives no grant", 32'(grant), 32'h0);

        // R2 R4: low bank, request 5 -> channel 9
        wr(16'h0100 + 16'(4*5), 32'h0000_0089);
        rd(16'h0114, v);
        chk("R2 readback req5", v, 32'h0000_0089);
        route(5, 32'h0000_0200, "R4 req5 to ch9");

        // R2: unused write bits dropped
        wr(16'h0104, 32'hFFFF_FF85);
        rd(16'h0104, v);
        chk("R2 only bits 7 and 4:0 kept", v, 32'h0000_0085);
        route(1, 32'h0000_0020, "R4 req1 to ch5");

        // R3: high bank, request 70 -> channel 31
        wr(16'h1118, 32'h0000_009F);
        rd(16'h1118, v);
        chk("R3 high bank readback", v, 32'h0000_009F);
        route(70, 32'h8000_0000, "R3 req70 to ch31");

        // R3: unaligned write ignored
        wr(16'h0101, 32'h0000_0080);
        rd(16'h0100, v);
        chk("R3 unaligned write ignored", v, 32'h0);
        route(0, 32'h0, "R3 req0 unrouted after unaligned write");

        // R3: request number not implemented
        wr(16'h1128, 32'h0000_0081);
        rd(16'h1128, v);
        chk("R3 unimplemented entry reads zero", v, 32'h0);

        // R5: valid bit clear routes nowhere
        wr(16'h011C, 32'h0000_000A);
        route(7, 32'h0, "R5 invalid mapping req7");

        // R6: two mappings onto channel 12
        wr(16'h0108, 32'h0000_008C);
        wr(16'h010C, 32'h0000_008C);
        route(2, 32'h0000_1000, "R6 req2 alone");
        route(3, 32'h0000_1000, "R6 req3 alone");
        periph_req[2] = 1'b1;
        periph_req[3] = 1'b1;
        tick();
        chk("R6 both requests", 32'(chan_req), 32'h0000_1000);
        periph_req = '0;
        tick();
        chk("R6 no request", 32'(chan_req), 32'h0);

        // R5: writing zero removes route
        wr(16'h0114, 32'h0);
        rd(16'h0114, v);
        chk("R5 removed mapping reads zero", v, 32'h0);
        route(5, 32'h0, "R5 removed route req5");

        // R4: one-cycle delay
        periph_req[70] = 1'b1;
        #1;
        chk("R4 no output before clock", 32'(chan_req), 32'h0);
        tick();
        chk("R4 output after clock", 32'(chan_req), 32'h8000_0000);
        periph_req = '0;
        tick();

        // R10: interrupt summary
        ch_irq_status[3*IRQ_W +: IRQ_W] = 4'b0100;
        #1;
        chk("R10 summary sets same cycle", 32'(irq_summary), 32'h0000_0008);
        ch_irq_status[30*IRQ_W +: IRQ_W] = 4'b1001;
        rd(16'h0080, v);
        chk("R10 summary register", v, 32'h4000_0008);
        ch_irq_status[3*IRQ_W +: IRQ_W] = 4'b0000;
        #1;
        chk("R10 summary clears same cycle", 32'(irq_summary), 32'h4000_0000);
        ch_irq_status = '0;
        #1;
        chk("R10 summary all clear", 32'(irq_summary), 32'h0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule